// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit general registers of a processor core that runs in several privilege modes. Part of the register set is replicated: the high registers 8 to 12 have an alternate copy for the fast-interrupt mode, and the stack and link registers (13 and 14) have one copy per mode group. Only the live set is read and written through the normal ports. The other copies are kept in a bank and swapped in when the core changes mode.

The core drives its current mode, which comes from its status register, on `cur_mode`. To change mode it pulses `mode_chg` with the target on `new_mode`. On that clock edge the live banked registers, and the live saved-status word if the old mode has one, go into the old mode's bank slots. The new mode's copies are then loaded. Two combinational read ports and one write port serve the current mode. A user-view port reaches the user-mode copies from a privileged mode, for user-register transfer instructions. A saved-status port reads and writes the current mode's saved status word and flags accesses in modes that have none.

Top module: `banked_regfile`

## Requirements
- R1: Registers 0–7 and 15 have a single copy in every mode. Reads on `rd_a`/`rd_b` are combinational from the live set. A write on the write port is visible from the cycle after its clock edge, and a mode change leaves these registers untouched.
- R2: Registers 8–12 have two copies. One is used only while the mode is FIQ (5'b10001), and every other mode shares the second one.
- R3: Registers 13 and 14 have six copies, one per group. The groups are User (5'b10000) and System (5'b11111) together, Supervisor (5'b10011), Abort (5'b10111), Undefined (5'b11011), IRQ (5'b10010) and FIQ. Any other encoding is handled as the User/System group and as non-FIQ.
- R4: A saved-status word exists for Supervisor, Abort, Undefined, IRQ and FIQ only. After a mode change, `spsr_rd_data` shows the new mode's saved copy.
- R5: A user-view access (`usr_addr` 8–12) in FIQ mode reaches the shared non-FIQ copy. In any other mode it reaches the live register.
- R6: A user-view access to register 13 or 14 in User or System mode reaches the live register. In any other mode it reaches the stored User/System copy.
- R7: After reset, register 13 = 0x03007F00 and register 15 = 0x08000000. The stored register 13 of the IRQ group is 0x03007FA0 and that of the Supervisor group is 0x03007FE0. All other registers, banked words and saved-status words are zero. The reset mode is System.
- R8: A saved-status read or write while `cur_mode` is User, System or an invalid encoding raises `spsr_err` in that cycle. The write is dropped and the read returns zero.
- R9: When a write (register or saved-status) and `mode_chg` fall in the same cycle, the write lands in the old mode's set and is saved into the old bank before the swap.
- R10: A mode change takes effect at the strobe's clock edge. From the next cycle the live registers 8–14 and the saved-status word hold the new mode's copies, and a later return to the old mode restores the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_mode | input | 5 | Current mode encoding |
| mode_chg | input | 1 | Mode change strobe |
| new_mode | input | 5 | Target mode, valid with `mode_chg` |
| rd_a_addr | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable, current mode |
| wr_addr | input | 4 | Write register number |
| wr_data | input | 32 | Write data |
| usr_addr | input | 4 | User-view register number (read and write) |
| usr_rd_data | output | 32 | User-view read data |
| usr_wr_en | input | 1 | User-view write enable |
| usr_wr_data | input | 32 | User-view write data |
| spsr_rd_en | input | 1 | Saved-status read strobe |
| spsr_wr_en | input | 1 | Saved-status write enable |
| spsr_wr_data | input | 32 | Saved-status write data |
| spsr_rd_data | output | 32 | Saved-status read data, current mode |
| spsr_err | output | 1 | Saved-status access in a mode without one |

## Verification
All read data and `spsr_err` are combinational, so they are due in the same cycle as the address or strobe. Writes and mode swaps land on the clock edge and show up one cycle later. The bench drives every step on the falling edge and samples the combinational outputs 1 ns after that, before the rising edge commits anything. A result of a write or a swap is therefore always checked in a later step, after its edge. The bench models the status register itself and updates the mode it drives only after the edge that took the strobe.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
  localparam int NREG     = 16;
  localparam int AW       = $clog2(NREG);
  localparam int HI_FIRST = 8;
  localparam int HI_CNT   = 5;
  localparam int SP_FIRST = 13;
  localparam int NUM_GRP  = 6;
  localparam int NUM_SPSR = 5;
  localparam int GW       = $clog2(NUM_GRP);
  localparam int SW       = $clog2(NUM_SPSR);

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  localparam logic [GW-1:0] GRP_USR = GW'(0);
  localparam logic [GW-1:0] GRP_SVC = GW'(1);
  localparam logic [GW-1:0] GRP_IRQ = GW'(4);

  // Stack/link group; invalid encodings fall into the user group.
  function automatic logic [GW-1:0] grp_of(input logic [4:0] m);
    case (m)
      MODE_SVC: return GW'(1);
      MODE_ABT: return GW'(2);
      MODE_UND: return GW'(3);
      MODE_IRQ: return GW'(4);
      MODE_FIQ: return GW'(5);
      default:  return GW'(0);
    endcase
  endfunction

  function automatic logic has_spsr(input logic [4:0] m);
    return (m == MODE_SVC) || (m == MODE_ABT) || (m == MODE_UND) ||
           (m == MODE_IRQ) || (m == MODE_FIQ);
  endfunction

  function automatic logic [SW-1:0] spsr_idx(input logic [4:0] m);
    case (m)
      MODE_ABT: return SW'(1);
      MODE_UND: return SW'(2);
      MODE_IRQ: return SW'(3);
      MODE_FIQ: return SW'(4);
      default:  return SW'(0);
    endcase
  endfunction

  function automatic logic is_fiq(input logic [4:0] m);
    return m == MODE_FIQ;
  endfunction

  function automatic logic addr_hi(input logic [AW-1:0] a);
    return (a >= AW'(HI_FIRST)) && (a < AW'(HI_FIRST + HI_CNT));
  endfunction

  function automatic logic addr_sp(input logic [AW-1:0] a);
    return (a == AW'(SP_FIRST)) || (a == AW'(SP_FIRST + 1));
  endfunction
endpackage

// File: rtl/rf_read_port.sv
module rf_read_port
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] regs [NREG],
  input  logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] data
);
  assign data = regs[addr];
endmodule

// File: rtl/rf_user_view.sv
module rf_user_view
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [4:0]        cur_mode,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] live      [NREG],
  input  logic [DATA_W-1:0] hi_shared [HI_CNT],
  input  logic [DATA_W-1:0] sp_user   [2],
  output logic [DATA_W-1:0] rd_data,
  output logic              to_hi,
  output logic              to_sp,
  output logic [2:0]        hi_i,
  output logic              sp_i
);
  always_comb begin
    to_hi   = is_fiq(cur_mode) && addr_hi(addr);
    to_sp   = (grp_of(cur_mode) != GRP_USR) && addr_sp(addr);
    hi_i    = 3'(addr - AW'(HI_FIRST));
    sp_i    = (addr == AW'(SP_FIRST + 1));
    if (to_hi)      rd_data = hi_shared[to_hi ? hi_i : 3'd0];
    else if (to_sp) rd_data = sp_user[sp_i];
    else            rd_data = live[addr];
  end
endmodule

// File: rtl/rf_spsr_port.sv
module rf_spsr_port
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [4:0]        cur_mode,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] live_spsr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_ok,
  output logic              err
);
  logic present;
  assign present = has_spsr(cur_mode);
  assign rd_data = present ? live_spsr : '0;
  assign wr_ok   = wr_en && present;
  assign err     = (rd_en || wr_en) && !present;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankrf_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter logic [DATA_W-1:0] BOOT_PC     = 'h0800_0000,
  parameter logic [DATA_W-1:0] BOOT_SP     = 'h0300_7F00,
  parameter logic [DATA_W-1:0] BOOT_SP_IRQ = 'h0300_7FA0,
  parameter logic [DATA_W-1:0] BOOT_SP_SVC = 'h0300_7FE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        cur_mode,
  input  logic              mode_chg,
  input  logic [4:0]        new_mode,
  input  logic [3:0]        rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        usr_addr,
  output logic [DATA_W-1:0] usr_rd_data,
  input  logic              usr_wr_en,
  input  logic [DATA_W-1:0] usr_wr_data,
  input  logic              spsr_rd_en,
  input  logic              spsr_wr_en,
  input  logic [DATA_W-1:0] spsr_wr_data,
  output logic [DATA_W-1:0] spsr_rd_data,
  output logic              spsr_err
);
  localparam int NRD = 2;

  // State: live set, alternate high copies, stack/link groups, saved status.
  logic [DATA_W-1:0] live_q      [NREG];
  logic [DATA_W-1:0] hi_q        [2][HI_CNT];
  logic [DATA_W-1:0] sp_q        [NUM_GRP][2];
  logic [DATA_W-1:0] spsr_bank_q [NUM_SPSR];
  logic [DATA_W-1:0] spsr_live_q;

  // Post-write view, then post-swap next state.
  logic [DATA_W-1:0] live_w [NREG];
  logic [DATA_W-1:0] hi_w   [2][HI_CNT];
  logic [DATA_W-1:0] sp_w   [NUM_GRP][2];
  logic [DATA_W-1:0] spsr_w;
  logic [DATA_W-1:0] live_n      [NREG];
  logic [DATA_W-1:0] hi_n        [2][HI_CNT];
  logic [DATA_W-1:0] sp_n        [NUM_GRP][2];
  logic [DATA_W-1:0] spsr_bank_n [NUM_SPSR];
  logic [DATA_W-1:0] spsr_live_n;

  // Named internal events for the checker.
  logic                    swap_ev;
  logic [DATA_W-1:0]       pc_q;
  logic [HI_CNT*DATA_W-1:0] hi_live;

  logic [GW-1:0] grp_old, grp_new;
  logic [SW-1:0] sidx_old, sidx_new;
  logic          fiq_old, fiq_new;

  assign swap_ev  = mode_chg;
  assign grp_old  = grp_of(cur_mode);
  assign grp_new  = grp_of(new_mode);
  assign sidx_old = spsr_idx(cur_mode);
  assign sidx_new = spsr_idx(new_mode);
  assign fiq_old  = is_fiq(cur_mode);
  assign fiq_new  = is_fiq(new_mode);
  assign pc_q     = live_q[NREG-1];

  generate
    for (genvar h = 0; h < HI_CNT; h++) begin : g_hi_flat
      assign hi_live[h*DATA_W +: DATA_W] = live_q[HI_FIRST+h];
    end
  endgenerate

  // Read ports
  logic [AW-1:0]     rd_addr_v [NRD];
  logic [DATA_W-1:0] rd_data_v [NRD];
  assign rd_addr_v[0] = rd_a_addr;
  assign rd_addr_v[1] = rd_b_addr;
  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      rf_read_port #(.DATA_W(DATA_W)) u_rd (
        .regs (live_q),
        .addr (rd_addr_v[p]),
        .data (rd_data_v[p])
      );
    end
  endgenerate
  assign rd_a_data = rd_data_v[0];
  assign rd_b_data = rd_data_v[1];

  // User-view port
  logic [DATA_W-1:0] hi_shared [HI_CNT];
  logic [DATA_W-1:0] sp_user   [2];
  logic              u_to_hi, u_to_sp, u_sp_i;
  logic [2:0]        u_hi_i;

  always_comb begin
    for (int i = 0; i < HI_CNT; i++) hi_shared[i] = hi_q[0][i];
    sp_user[0] = sp_q[GRP_USR][0];
    sp_user[1] = sp_q[GRP_USR][1];
  end

  rf_user_view #(.DATA_W(DATA_W)) u_usr (
    .cur_mode  (cur_mode),
    .addr      (usr_addr),
    .live      (live_q),
    .hi_shared (hi_shared),
    .sp_user   (sp_user),
    .rd_data   (usr_rd_data),
    .to_hi     (u_to_hi),
    .to_sp     (u_to_sp),
    .hi_i      (u_hi_i),
    .sp_i      (u_sp_i)
  );

  // Saved-status port
  logic spsr_wr_ok;
  rf_spsr_port #(.DATA_W(DATA_W)) u_spsr (
    .cur_mode  (cur_mode),
    .rd_en     (spsr_rd_en),
    .wr_en     (spsr_wr_en),
    .live_spsr (spsr_live_q),
    .rd_data   (spsr_rd_data),
    .wr_ok     (spsr_wr_ok),
    .err       (spsr_err)
  );

  // Writes first (old mode's view), then the swap on top of them.
  always_comb begin
    live_w = live_q;
    hi_w   = hi_q;
    sp_w   = sp_q;
    spsr_w = spsr_live_q;
    if (wr_en) live_w[wr_addr] = wr_data;
    if (usr_wr_en) begin
      if (u_to_hi)      hi_w[0][u_hi_i]       = usr_wr_data;
      else if (u_to_sp) sp_w[GRP_USR][u_sp_i] = usr_wr_data;
      else              live_w[usr_addr]      = usr_wr_data;
    end
    if (spsr_wr_ok) spsr_w = spsr_wr_data;

    live_n      = live_w;
    hi_n        = hi_w;
    sp_n        = sp_w;
    spsr_bank_n = spsr_bank_q;
    spsr_live_n = spsr_w;
    if (swap_ev) begin
      for (int i = 0; i < HI_CNT; i++) hi_n[fiq_old][i] = live_w[HI_FIRST+i];
      sp_n[grp_old][0] = live_w[SP_FIRST];
      sp_n[grp_old][1] = live_w[SP_FIRST+1];
      if (has_spsr(cur_mode)) spsr_bank_n[sidx_old] = spsr_w;
      for (int i = 0; i < HI_CNT; i++) live_n[HI_FIRST+i] = hi_n[fiq_new][i];
      live_n[SP_FIRST]   = sp_n[grp_new][0];
      live_n[SP_FIRST+1] = sp_n[grp_new][1];
      spsr_live_n = has_spsr(new_mode) ? spsr_bank_n[sidx_new] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) live_q[i] <= '0;
      live_q[SP_FIRST] <= BOOT_SP;
      live_q[NREG-1]   <= BOOT_PC;
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < HI_CNT; i++) hi_q[c][i] <= '0;
      for (int g = 0; g < NUM_GRP; g++) begin
        sp_q[g][0] <= '0;
        sp_q[g][1] <= '0;
      end
      sp_q[GRP_IRQ][0] <= BOOT_SP_IRQ;
      sp_q[GRP_SVC][0] <= BOOT_SP_SVC;
      for (int s = 0; s < NUM_SPSR; s++) spsr_bank_q[s] <= '0;
      spsr_live_q <= '0;
    end else begin
      live_q      <= live_n;
      hi_q        <= hi_n;
      sp_q        <= sp_n;
      spsr_bank_q <= spsr_bank_n;
      spsr_live_q <= spsr_live_n;
    end
  end
endmodule

// File: rtl/bankrf_checker.sv
module bankrf_checker
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [4:0]               cur_mode,
  input logic [4:0]               new_mode,
  input logic                     swap_ev,
  input logic                     wr_en,
  input logic [3:0]               wr_addr,
  input logic                     usr_wr_en,
  input logic [3:0]               usr_addr,
  input logic                     spsr_rd_en,
  input logic                     spsr_wr_en,
  input logic [DATA_W-1:0]        spsr_rd_data,
  input logic                     spsr_err,
  input logic [DATA_W-1:0]        pc_q,
  input logic [HI_CNT*DATA_W-1:0] hi_live,
  input logic [DATA_W-1:0]        spsr_live_q
);
  logic pc_touched, hi_touched;
  assign pc_touched = (wr_en && wr_addr == 4'd15) || (usr_wr_en && usr_addr == 4'd15);
  assign hi_touched = (wr_en && addr_hi(wr_addr)) || (usr_wr_en && addr_hi(usr_addr));

  AST_PC_UNBANKED: assert property (@(posedge clk) disable iff (!rst_n)
    swap_ev && !pc_touched |=> $stable(pc_q)); // R1

  AST_HI_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    swap_ev && !is_fiq(cur_mode) && !is_fiq(new_mode) && !hi_touched
    |=> $stable(hi_live)); // R2

  AST_SPSR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    swap_ev && !has_spsr(new_mode) |=> spsr_live_q == '0); // R4

  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_err |-> spsr_rd_data == '0); // R8

  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_err |-> (spsr_rd_en || spsr_wr_en)); // R8
endmodule

bind banked_regfile bankrf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cur_mode     (cur_mode),
  .new_mode     (new_mode),
  .swap_ev      (swap_ev),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .usr_wr_en    (usr_wr_en),
  .usr_addr     (usr_addr),
  .spsr_rd_en   (spsr_rd_en),
  .spsr_wr_en   (spsr_wr_en),
  .spsr_rd_data (spsr_rd_data),
  .spsr_err     (spsr_err),
  .pc_q         (pc_q),
  .hi_live      (hi_live),
  .spsr_live_q  (spsr_live_q)
);

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;
  localparam int WD_CYCLES = 20000;
  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111;
  localparam logic [2:0] OP_W = 3'd0, OP_M = 3'd1, OP_RA = 3'd2, OP_RB = 3'd3,
                         OP_UW = 3'd4, OP_UR = 3'd5, OP_SW = 3'd6, OP_SR = 3'd7;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  req;
    logic [3:0]  addr;
    logic [4:0]  mode;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VECS [NV] = '{
    '{OP_W,  4'd1,  4'd0,  SYS, 32'h1111_1111, 32'h0},
    '{OP_W,  4'd2,  4'd8,  SYS, 32'h8888_0000, 32'h0},
    '{OP_W,  4'd3,  4'd13, SYS, 32'h1313_0000, 32'h0},
    '{OP_RA, 4'd1,  4'd0,  SYS, 32'h0, 32'h1111_1111},  // R1
    '{OP_RB, 4'd3,  4'd13, SYS, 32'h0, 32'h1313_0000},  // R3
    '{OP_M,  4'd10, 4'd0,  IRQ, 32'h0, 32'h0},
    '{OP_RA, 4'd7,  4'd13, IRQ, 32'h0, 32'h0300_7FA0},  // R7
    '{OP_RB, 4'd2,  4'd8,  IRQ, 32'h0, 32'h8888_0000},  // R2
    '{OP_RA, 4'd1,  4'd0,  IRQ, 32'h0, 32'h1111_1111},  // R1
    '{OP_UR, 4'd6,  4'd13, IRQ, 32'h0, 32'h1313_0000},  // R6
    '{OP_SW, 4'd4,  4'd0,  IRQ, 32'h5A5A_0001, 32'h0},
    '{OP_SR, 4'd4,  4'd0,  IRQ, 32'h0, 32'h5A5A_0001},  // R4
    '{OP_W,  4'd3,  4'd13, IRQ, 32'hA1A1_A1A1, 32'h0},
    '{OP_W,  4'd3,  4'd14, IRQ, 32'hE14E_0000, 32'h0},
    '{OP_M,  4'd10, 4'd0,  FIQ, 32'h0, 32'h0},
    '{OP_RA, 4'd2,  4'd8,  FIQ, 32'h0, 32'h0},          // R2
    '{OP_RA, 4'd3,  4'd13, FIQ, 32'h0, 32'h0},          // R3
    '{OP_UR, 4'd5,  4'd8,  FIQ, 32'h0, 32'h8888_0000},  // R5
    '{OP_W,  4'd2,  4'd8,  FIQ, 32'hF8F8_0000, 32'h0},
    '{OP_UW, 4'd5,  4'd9,  FIQ, 32'h9999_0000, 32'h0},
    '{OP_SR, 4'd4,  4'd0,  FIQ, 32'h0, 32'h0},          // R4
    '{OP_M,  4'd10, 4'd0,  SVC, 32'h0, 32'h0},
    '{OP_RA, 4'd2,  4'd8,  SVC, 32'h0, 32'h8888_0000},  // R2
    '{OP_RB, 4'd5,  4'd9,  SVC, 32'h0, 32'h9999_0000},  // R5
    '{OP_RA, 4'd7,  4'd13, SVC, 32'h0, 32'h0300_7FE0},  // R7
    '{OP_SR, 4'd4,  4'd0,  SVC, 32'h0, 32'h0},          // R4
    '{OP_M,  4'd10, 4'd0,  IRQ, 32'h0, 32'h0},
    '{OP_RA, 4'd10, 4'd13, IRQ, 32'h0, 32'hA1A1_A1A1},  // R10
    '{OP_RB, 4'd10, 4'd14, IRQ, 32'h0, 32'hE14E_0000},  // R10
    '{OP_SR, 4'd4,  4'd0,  IRQ, 32'h0, 32'h5A5A_0001},  // R4
    '{OP_M,  4'd10, 4'd0,  FIQ, 32'h0, 32'h0},
    '{OP_RA, 4'd2,  4'd8,  FIQ, 32'h0, 32'hF8F8_0000},  // R2
    '{OP_UW, 4'd6,  4'd13, FIQ, 32'h0D0D_0000, 32'h0},
    '{OP_UR, 4'd6,  4'd13, FIQ, 32'h0, 32'h0D0D_0000},  // R6
    '{OP_M,  4'd10, 4'd0,  USR, 32'h0, 32'h0},
    '{OP_RA, 4'd3,  4'd13, USR, 32'h0, 32'h0D0D_0000},  // R3
    '{OP_RB, 4'd2,  4'd8,  USR, 32'h0, 32'h8888_0000},  // R2
    '{OP_UR, 4'd6,  4'd14, USR, 32'h0, 32'h0},          // R6
    '{OP_RA, 4'd1,  4'd15, USR, 32'h0, 32'h0800_0000}   // R1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cur_mode = SYS;
  logic        mode_chg = 1'b0;
  logic [4:0]  new_mode = SYS;
  logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0, usr_addr = '0;
  logic        wr_en = 1'b0, usr_wr_en = 1'b0, spsr_rd_en = 1'b0, spsr_wr_en = 1'b0;
  logic [31:0] wr_data = '0, usr_wr_data = '0, spsr_wr_data = '0;
  logic [31:0] rd_a_data, rd_b_data, usr_rd_data, spsr_rd_data;
  logic        spsr_err;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  banked_regfile dut (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .mode_chg(mode_chg),
    .new_mode(new_mode), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .usr_addr(usr_addr),
    .usr_rd_data(usr_rd_data), .usr_wr_en(usr_wr_en), .usr_wr_data(usr_wr_data),
    .spsr_rd_en(spsr_rd_en), .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data),
    .spsr_rd_data(spsr_rd_data), .spsr_err(spsr_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    mode_chg = 1'b0; wr_en = 1'b0; usr_wr_en = 1'b0;
    spsr_rd_en = 1'b0; spsr_wr_en = 1'b0;
  endtask

  // Drive at the falling edge, sample combinational results 1 ns later,
  // let the rising edge commit, then update the modelled mode.
  task automatic step(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    idle();
    case (v.op)
      OP_W:  begin wr_en = 1'b1; wr_addr = v.addr; wr_data = v.data; end
      OP_M:  begin mode_chg = 1'b1; new_mode = v.mode; end
      OP_RA: rd_a_addr = v.addr;
      OP_RB: rd_b_addr = v.addr;
      OP_UW: begin usr_wr_en = 1'b1; usr_addr = v.addr; usr_wr_data = v.data; end
      OP_UR: usr_addr = v.addr;
      OP_SW: begin spsr_wr_en = 1'b1; spsr_wr_data = v.data; end
      default: spsr_rd_en = 1'b1;
    endcase
    #1;
    case (v.op)
      OP_RA: chk(tag, rd_a_data, v.exp);
      OP_RB: chk(tag, rd_b_data, v.exp);
      OP_UR: chk(tag, usr_rd_data, v.exp);
      OP_SR: chk(tag, spsr_rd_data, v.exp);
      default: ;
    endcase
    @(posedge clk);
    #1;
    idle();
    if (v.op == OP_M) cur_mode = v.mode;
  endtask

  function automatic vec_t mk(input logic [2:0] op, input logic [3:0] req,
                              input logic [3:0] a, input logic [4:0] m,
                              input logic [31:0] d, input logic [31:0] e);
    vec_t v;
    v.op = op; v.req = req; v.addr = a; v.mode = m; v.data = d; v.exp = e;
    return v;
  endfunction

  initial begin : watchdog
    #(WD_CYCLES * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R7: boot state, System mode, read before any write
    @(negedge clk);
    rd_a_addr = 4'd13; rd_b_addr = 4'd15; usr_addr = 4'd8;
    #1;
    chk("R7 boot r13", rd_a_data, 32'h0300_7F00);
    chk("R7 boot r15", rd_b_data, 32'h0800_0000);
    chk("R7 boot r8", usr_rd_data, 32'h0);
    spsr_rd_en = 1'b1;
    #1;
    chk("R8 sys read err", {31'h0, spsr_err}, 32'h1);
    chk("R8 sys read zero", spsr_rd_data, 32'h0);
    idle();

    for (int i = 0; i < NV; i++) step(VECS[i]);

    // R9: register write together with a swap lands in the old (user) group
    @(negedge clk);
    mode_chg = 1'b1; new_mode = ABT;
    wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'hCAFE_0001;
    @(posedge clk); #1; idle(); cur_mode = ABT;
    step(mk(OP_RA, 4'd9, 4'd13, ABT, 32'h0, 32'h0));
    step(mk(OP_M, 4'd9, 4'd0, USR, 32'h0, 32'h0));
    step(mk(OP_RA, 4'd9, 4'd13, USR, 32'h0, 32'hCAFE_0001));

    // R9: saved-status write with a swap is stored in the old mode's slot
    step(mk(OP_M, 4'd10, 4'd0, IRQ, 32'h0, 32'h0));
    @(negedge clk);
    mode_chg = 1'b1; new_mode = SVC;
    spsr_wr_en = 1'b1; spsr_wr_data = 32'h7777_0000;
    @(posedge clk); #1; idle(); cur_mode = SVC;
    step(mk(OP_SR, 4'd9, 4'd0, SVC, 32'h0, 32'h0));
    step(mk(OP_M, 4'd9, 4'd0, IRQ, 32'h0, 32'h0));
    step(mk(OP_SR, 4'd9, 4'd0, IRQ, 32'h0, 32'h7777_0000));

    // R8: write in System is flagged and reads back zero
    step(mk(OP_M, 4'd8, 4'd0, SYS, 32'h0, 32'h0));
    @(negedge clk);
    spsr_wr_en = 1'b1; spsr_wr_data = 32'hDEAD_BEEF;
    #1;
    chk("R8 sys write err", {31'h0, spsr_err}, 32'h1);
    @(posedge clk); #1; idle();
    @(negedge clk);
    spsr_rd_en = 1'b1;
    #1;
    chk("R8 sys read after write", spsr_rd_data, 32'h0);
    idle();
    #1;
    chk("R8 no access no err", {31'h0, spsr_err}, 32'h0);

    // R8: invalid encoding flags the access; R3: it uses the user group
    @(negedge clk);
    cur_mode = 5'b00101;
    spsr_rd_en = 1'b1; rd_a_addr = 4'd13;
    #1;
    chk("R8 invalid mode err", {31'h0, spsr_err}, 32'h1);
    chk("R3 invalid mode user r13", rd_a_data, 32'hCAFE_0001);
    idle();
    cur_mode = SYS;

    // R4: a mode with a saved word raises no error
    step(mk(OP_M, 4'd4, 4'd0, UND, 32'h0, 32'h0));
    @(negedge clk);
    spsr_rd_en = 1'b1;
    #1;
    chk("R4 und read no err", {31'h0, spsr_err}, 32'h0);
    chk("R4 und spsr zero", spsr_rd_data, 32'h0);
    idle();

    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule